// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the operand address for a load/store pipeline stage. Each request carries a mode selector, a base register value, an index register value, an instruction offset and an element-size code. The block returns one registered result: a byte address or a literal operand.

In the two address modes, the offset is sign-extended and added to the base, which marks the start of a user memory region. In indexed mode, the index is also added after a left shift by the element size, so array subscripts need no multiplier. Literal mode skips address formation and returns the sign-extended immediate as a value. The fourth mode code is reserved and reports an error.

The result appears one clock after the request and is held until the next request. A request can be issued on every cycle.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid`, `out_value`, `out_is_literal` and `out_illegal` are all zero.
- R2: With `in_mode` = 2'b00 (base), `out_value` = `in_base` + sign-extended `in_offset`, with `out_is_literal` = 0 and `out_illegal` = 0.
- R3: With `in_mode` = 2'b01 (indexed), `out_value` = `in_base` + sign-extended `in_offset` + (`in_index` << `in_size`).
- R4: `in_size` codes 0, 1, 2 and 3 scale the index by 1, 2, 4 and 8 bytes.
- R5: `in_offset` is a two's-complement value. Bit 15 set makes it negative, so the address falls below the base.
- R6: All address arithmetic wraps modulo 2^32. Index bits shifted past bit 31 are dropped.
- R7: With `in_mode` = 2'b10 (literal), `out_value` = sign-extended `in_offset` and `out_is_literal` = 1. `in_base`, `in_index` and `in_size` have no effect.
- R8: With `in_mode` = 2'b11 (reserved), `out_illegal` = 1, `out_value` = 0 and `out_is_literal` = 0.
- R9: `out_valid` is `in_valid` delayed by one clock. Requests on consecutive cycles each produce their own result on consecutive cycles.
- R10: In a cycle where `in_valid` is low, `out_value`, `out_is_literal` and `out_illegal` keep their previous values, whatever the other inputs do.
- R11: In base mode, `in_index` and `in_size` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | Addressing mode: 00 base, 01 indexed, 10 literal, 11 reserved |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_offset | input | 16 | Instruction offset or immediate, two's complement |
| in_size | input | 2 | Element-size code, shift of 0 to 3 |
| out_valid | output | 1 | Result present |
| out_value | output | 32 | Effective byte address or literal operand |
| out_is_literal | output | 1 | Result is an operand, not an address |
| out_illegal | output | 1 | Reserved mode was requested |

## Verification
Two effects can act on one indexed result in the same cycle: a scaled index that loses high bits in the shift, and a three-way sum that carries past bit 31. The bench provokes this with an all-ones base, an offset of minus one and an index of 0x8000_0001 scaled by two. The expected result is exactly zero. A design that keeps either the lost index bit or the carry gives a nonzero value.

Back-to-back requests are also sent with a different mode in each cycle. Each registered result is checked against its own request, which shows that no mode's flags or value leak into the next result.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int EAG_XLEN  = 32;
    localparam int EAG_OFF_W = 16;
    localparam int EAG_SZ_W  = 2;

    typedef enum logic [1:0] {
        AM_BASE    = 2'b00,
        AM_INDEXED = 2'b01,
        AM_LITERAL = 2'b10,
        AM_RSVD    = 2'b11
    } am_mode_e;

    typedef struct packed {
        logic add_index;
        logic literal;
        logic illegal;
    } am_ctrl_t;

    function automatic am_ctrl_t am_decode(input am_mode_e m);
        am_ctrl_t c;
        c = '0;
        unique case (m)
            AM_BASE:    c = '0;
            AM_INDEXED: c.add_index = 1'b1;
            AM_LITERAL: c.literal   = 1'b1;
            AM_RSVD:    c.illegal   = 1'b1;
            default:    c.illegal   = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eag_scaler.sv
module eag_scaler #(
    parameter int XLEN = 32,
    parameter int SZ_W = 2
) (
    input  logic [XLEN-1:0] idx,
    input  logic [SZ_W-1:0] size_code,
    output logic [XLEN-1:0] scaled
);
    localparam int STAGES = SZ_W;

    logic [XLEN-1:0] stage [STAGES+1];

    assign stage[0] = idx;

    for (genvar k = 0; k < STAGES; k++) begin : g_shift
        localparam int AMT = 1 << k;
        assign stage[k+1] = size_code[k] ? (stage[k] << AMT) : stage[k];
    end

    assign scaled = stage[STAGES];
endmodule

// File: rtl/eag_combine.sv
module eag_combine
    import eag_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  am_ctrl_t        ctrl,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] off_ext,
    input  logic [XLEN-1:0] idx_scaled,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] idx_term;
    logic [XLEN-1:0] addr_sum;

    always_comb begin
        idx_term = ctrl.add_index ? idx_scaled : '0;
        addr_sum = base + off_ext + idx_term;
        if (ctrl.literal)
            result = off_ext;
        else if (ctrl.illegal)
            result = '0;
        else
            result = addr_sum;
    end
endmodule

// File: rtl/eag_outreg.sv
module eag_outreg
    import eag_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  am_ctrl_t        ctrl,
    input  logic [XLEN-1:0] value_d,
    output logic            valid_q,
    output logic [XLEN-1:0] value_q,
    output logic            lit_q,
    output logic            ill_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            value_q <= '0;
            lit_q   <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) begin
                value_q <= value_d;
                lit_q   <= ctrl.literal;
                ill_q   <= ctrl.illegal;
            end
        end
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int XLEN  = EAG_XLEN,
    parameter int OFF_W = EAG_OFF_W,
    parameter int SZ_W  = EAG_SZ_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic [XLEN-1:0]  in_base,
    input  logic [XLEN-1:0]  in_index,
    input  logic [OFF_W-1:0] in_offset,
    input  logic [SZ_W-1:0]  in_size,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_value,
    output logic             out_is_literal,
    output logic             out_illegal
);
    localparam int EXT_W = XLEN - OFF_W;

    am_ctrl_t        ctrl;
    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] idx_scaled;
    logic [XLEN-1:0] result;

    assign ctrl    = am_decode(am_mode_e'(in_mode));
    assign off_ext = {{EXT_W{in_offset[OFF_W-1]}}, in_offset};

    eag_scaler #(.XLEN(XLEN), .SZ_W(SZ_W)) u_scaler (
        .idx       (in_index),
        .size_code (in_size),
        .scaled    (idx_scaled)
    );

    eag_combine #(.XLEN(XLEN)) u_combine (
        .ctrl       (ctrl),
        .base       (in_base),
        .off_ext    (off_ext),
        .idx_scaled (idx_scaled),
        .result     (result)
    );

    eag_outreg #(.XLEN(XLEN)) u_outreg (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .ctrl    (ctrl),
        .value_d (result),
        .valid_q (out_valid),
        .value_q (out_value),
        .lit_q   (out_is_literal),
        .ill_q   (out_illegal)
    );
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int SZ_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_mode,
    input logic [XLEN-1:0]  in_base,
    input logic [XLEN-1:0]  in_index,
    input logic [OFF_W-1:0] in_offset,
    input logic [SZ_W-1:0]  in_size,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_value,
    input logic             out_is_literal,
    input logic             out_illegal
);
    logic [XLEN-1:0] sx_off;
    assign sx_off = XLEN'($signed(in_offset));

    // R9: a request yields a result on the next clock
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: no request, no result
    a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: base-mode sum
    a_r2_base_sum: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b00) |=>
            (out_value == $past(in_base + sx_off)) && !out_is_literal && !out_illegal);

    // R7: literal passes the immediate through
    a_r7_literal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b10) |=>
            out_is_literal && !out_illegal && (out_value == $past(sx_off)));

    // R8: reserved mode yields zero and the error flag
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11) |=>
            out_illegal && !out_is_literal && (out_value == '0));

    // R8: the two flags never rise together
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_is_literal && out_illegal));

    // R10: results hold while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_value) && $stable(out_is_literal) && $stable(out_illegal));
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.XLEN(XLEN), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_chk (.*);

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic [31:0] in_base = '0;
    logic [31:0] in_index = '0;
    logic [15:0] in_offset = '0;
    logic [1:0]  in_size = '0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_is_literal;
    logic        out_illegal;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    eff_addr_gen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_base(in_base), .in_index(in_index), .in_offset(in_offset),
        .in_size(in_size), .out_valid(out_valid), .out_value(out_value),
        .out_is_literal(out_is_literal), .out_illegal(out_illegal)
    );

    function automatic logic [31:0] sx(input logic [15:0] o);
        return {{16{o[15]}}, o};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [31:0] v, input logic lit, input logic ill);
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check({req, " value"}, out_value, v);
        check({req, " literal"}, {31'b0, out_is_literal}, {31'b0, lit});
        check({req, " illegal"}, {31'b0, out_illegal}, {31'b0, ill});
    endtask

    task automatic drive(input logic [1:0] m, input logic [31:0] b, input logic [31:0] x,
                         input logic [15:0] o, input logic [1:0] s);
        in_valid = 1'b1; in_mode = m; in_base = b; in_index = x; in_offset = o; in_size = s;
    endtask

    task automatic one_req(input logic [1:0] m, input logic [31:0] b, input logic [31:0] x,
                           input logic [15:0] o, input logic [1:0] s);
        @(negedge clk);
        drive(m, b, x, o, s);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 value", out_value, 32'd0);
        check("R1 flags", {30'b0, out_is_literal, out_illegal}, 32'd0);
    endtask

    task automatic t_base;
        one_req(2'b00, 32'h0000_1000, 32'h0, 16'h0010, 2'd0);
        check_out("R2", 32'h0000_1010, 1'b0, 1'b0);
        one_req(2'b00, 32'h0000_1000, 32'hFFFF_FFFF, 16'h0010, 2'd3);
        check_out("R11", 32'h0000_1010, 1'b0, 1'b0);
    endtask

    task automatic t_indexed;
        for (int s = 0; s < 4; s++) begin
            one_req(2'b01, 32'h0000_2000, 32'd5, 16'h0004, 2'(s));
            check_out("R3 R4", 32'h0000_2004 + (32'd5 << s), 1'b0, 1'b0);
        end
    endtask

    task automatic t_negative;
        one_req(2'b00, 32'h0000_0100, 32'h0, 16'hFFF0, 2'd0);
        check_out("R5", 32'h0000_00F0, 1'b0, 1'b0);
    endtask

    task automatic t_wrap;
        one_req(2'b00, 32'hFFFF_FFF0, 32'h0, 16'h0020, 2'd0);
        check_out("R6 carry", 32'h0000_0010, 1'b0, 1'b0);
        one_req(2'b01, 32'hFFFF_FFFF, 32'h8000_0001, 16'hFFFF, 2'd1);
        check_out("R6 shift+carry", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_literal;
        one_req(2'b10, 32'h0000_DEAD, 32'd7, 16'h8001, 2'd2);
        check_out("R7", 32'hFFFF_8001, 1'b1, 1'b0);
        one_req(2'b10, 32'h1234_5678, 32'hFFFF_FFFF, 16'h007F, 2'd3);
        check_out("R7 pos", 32'h0000_007F, 1'b1, 1'b0);
    endtask

    task automatic t_reserved;
        one_req(2'b11, 32'h0000_4000, 32'd3, 16'h0008, 2'd1);
        check_out("R8", 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(2'b10, 32'h0, 32'h0, 16'h0042, 2'd0);
        @(negedge clk);
        check_out("R9 first", 32'h0000_0042, 1'b1, 1'b0);
        drive(2'b11, 32'h55, 32'h1, 16'h1, 2'd0);
        @(negedge clk);
        check_out("R9 second", 32'h0, 1'b0, 1'b1);
        drive(2'b01, 32'h0000_3000, 32'd2, 16'h0001, 2'd2);
        @(negedge clk);
        check_out("R9 third", 32'h0000_3009, 1'b0, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 idle", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_hold;
        one_req(2'b00, 32'h0000_7000, 32'h0, 16'h0007, 2'd0);
        in_mode = 2'b10; in_base = 32'hAAAA_AAAA; in_offset = 16'h9999;
        @(negedge clk);
        in_mode = 2'b11;
        @(negedge clk);
        check("R10 valid", {31'b0, out_valid}, 32'd0);
        check("R10 value", out_value, 32'h0000_7007);
        check("R10 flags", {30'b0, out_is_literal, out_illegal}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_base();
        t_indexed();
        t_negative();
        t_wrap();
        t_literal();
        t_reserved();
        t_back_to_back();
        t_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule